// File: doc/BRIEF.md
# Node Home-Directory Coherence Controller

This block is the coherence agent of one node in a multi-node shared-memory machine. Every line address carries its home node in its top bits. The controller sits between the node's local snooping bus, a point-to-point message link to the other nodes, and the node's slice of main memory. A local read or read-for-ownership whose address is homed elsewhere goes out as a request to the home node. The controller then holds further local traffic until the data message comes back, and returns that data on the local bus as a response.

For lines homed on this node, the controller keeps a directory entry per line. Each entry holds one presence bit per remote node plus a dirty flag and an owner number. A dirty line means the memory copy is stale. Requests from remote nodes and from the local bus are served from memory. Before serving, the controller sends invalidations to the nodes holding copies when a node takes ownership. When another requester needs a stale line, it first recalls the line from the owner. A writeback arriving from a remote node refreshes memory and clears the dirty state. Invalidations and recalls addressed to this node appear as purge pulses for the local caches.

The engine serves one transaction at a time. An incoming message wins over a local request when both are offered in the same cycle.

Top module: `node_dir_ctrl`

## Requirements
- R1: While reset is held and right after it, outValid, locRespValid, purgeValid and memWe are 0, and locReady and inReady are 1.
- R2: A local read (kind 0) or read-for-ownership (kind 1) to an address whose bits [7:6] differ from the node number goes out once, with the same kind and address, addressed to the single node named by bits [7:6]. In outDstMask, bit n selects node n.
- R3: A data message (kind 5) that arrives while a remote request is open produces one locRespValid pulse that carries the message data.
- R4: While a remote request is open and its response has not yet arrived, locReady stays 0.
- R5: A remote read (kind 0) of a clean home line returns a data message (kind 5) with the memory contents to the requesting node alone. The requester is then recorded as a sharer.
- R6: A local read of a clean home line returns the memory contents on the local response and sends no link message.
- R7: A remote read-for-ownership of a home line sends one invalidate (kind 3) to the other sharers only, pulses a local purge of that address, then sends the data to the requester. The requester becomes the dirty owner.
- R8: A request for a home line that a different node owns dirty first sends a recall (kind 4) to the owner and returns no data. When the owner's writeback (kind 2) arrives, the writeback data goes to memory and is used for the reply.
- R9: A local read-for-ownership of a home line invalidates all remote sharers and clears the entry, so a later remote read-for-ownership of that line sends no invalidate.
- R10: An incoming invalidate or recall produces a purge pulse at its address, also while a remote request is open.
- R11: A remote writeback of a home line writes memory and clears both the dirty state and the writer's presence bit, so a later local read-for-ownership sends neither a recall nor an invalidate.
- R12: A local writeback (kind 2) to a remotely homed address is forwarded once to the home node with its data, and produces no local response.
- R13: When a link message and a local request are offered in the same idle cycle, the link message is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| locValid | input | 1 | Local bus request valid |
| locKind | input | 3 | Local request kind: 0 read, 1 read-for-ownership, 2 writeback |
| locAddr | input | 8 | Local request line address |
| locWdata | input | 16 | Local writeback data |
| locReady | output | 1 | Local request accepted this cycle |
| locRespValid | output | 1 | Local response pulse |
| locRespData | output | 16 | Local response data |
| inValid | input | 1 | Incoming link message valid |
| inKind | input | 3 | Incoming kind: 0 read, 1 read-for-ownership, 2 writeback, 3 invalidate, 4 recall, 5 data |
| inSrc | input | 2 | Sending node of incoming message |
| inAddr | input | 8 | Incoming message address |
| inData | input | 16 | Incoming message data |
| inReady | output | 1 | Incoming message accepted this cycle |
| outValid | output | 1 | Outgoing link message pulse |
| outKind | output | 3 | Outgoing message kind, same codes as inKind |
| outDstMask | output | 4 | Destination nodes, one bit per node |
| outAddr | output | 8 | Outgoing message address |
| outData | output | 16 | Outgoing message data |
| memRe | output | 1 | Memory read strobe, data expected one cycle later |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | 6 | Memory line index |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data |
| purgeValid | output | 1 | Purge pulse for local caches |
| purgeAddr | output | 8 | Address to purge |

## Verification
Remote-homed reads and ownership requests go out to each of the three other nodes, with varied data. This shows that the home decode and the response return work for every destination. A single home line is then taken through a fixed life cycle: local read, two remote sharers, a remote ownership take, a local read that forces a recall, a local ownership take, a remote ownership take and a remote writeback. Each step leaves directory state that the next step can only reveal through the invalidates or recalls it does or does not send. A purge arriving during an open request, and a link message colliding with a local request, tell apart the blocking and priority rules.

// File: rtl/node_dir_pkg.sv
package node_dir_pkg;

  typedef enum logic [2:0] {
    K_RD     = 3'd0,
    K_RWITM  = 3'd1,
    K_WB     = 3'd2,
    K_INV    = 3'd3,
    K_RECALL = 3'd4,
    K_DATA   = 3'd5
  } msgKind_e;

  typedef enum logic [2:0] {
    D_NONE, D_SHARE, D_TAKE, D_CLEAR, D_CLEAN, D_EVICT
  } dirOp_e;

  typedef enum logic [1:0] {
    T_HOME, T_SRC, T_OWNER, T_SHARERS
  } dstSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     capLoc;
    logic     capIn;
    logic     memRe;
    logic     memWe;
    logic     wbFromIn;
    dirOp_e   dirOp;
    logic     send;
    msgKind_e sendKind;
    dstSel_e  dstSel;
    logic     purge;
    logic     purgeFromIn;
    logic     resp;
    logic     respFromIn;
  } strobe_t;

  // facts about the pending transaction, datapath to control
  typedef struct packed {
    msgKind_e kind;
    logic     fromLoc;
    logic     remoteHome;
    logic     dirty;
    logic     ownerIsSrc;
    logic     invAny;
  } status_t;

endpackage

// File: rtl/node_dir_ctl.sv
module node_dir_ctl
  import node_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       locValid,
  input  logic       inValid,
  input  logic [2:0] inKind,
  input  logic       inAddrMatch,
  input  status_t    stat,
  output strobe_t    stb,
  output logic       locReady,
  output logic       inReady
);

  typedef enum logic [2:0] {S_IDLE, S_DECIDE, S_MEMRD, S_WAITWB, S_WAITRSP} state_e;
  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    locReady  = 1'b0;
    inReady   = 1'b0;
    case (state)
      S_IDLE: begin
        inReady  = 1'b1;
        locReady = !inValid;
        if (inValid) begin
          stb.capIn = 1'b1;
          nextState = S_DECIDE;
        end else if (locValid) begin
          stb.capLoc = 1'b1;
          nextState  = S_DECIDE;
        end
      end
      S_DECIDE: begin
        nextState = S_IDLE;
        case (stat.kind)
          K_INV, K_RECALL: stb.purge = 1'b1;
          K_WB: begin
            if (stat.remoteHome) begin
              stb.send     = 1'b1;
              stb.sendKind = K_WB;
              stb.dstSel   = T_HOME;
            end else begin
              stb.memWe = 1'b1;
              stb.dirOp = stat.fromLoc ? D_NONE : D_EVICT;
            end
          end
          K_RD, K_RWITM: begin
            if (stat.remoteHome) begin
              stb.send     = 1'b1;
              stb.sendKind = stat.kind;
              stb.dstSel   = T_HOME;
              nextState    = S_WAITRSP;
            end else if (stat.dirty && !stat.ownerIsSrc) begin
              stb.send     = 1'b1;
              stb.sendKind = K_RECALL;
              stb.dstSel   = T_OWNER;
              nextState    = S_WAITWB;
            end else begin
              stb.memRe = 1'b1;
              if (stat.kind == K_RWITM) begin
                stb.send     = stat.invAny;
                stb.sendKind = K_INV;
                stb.dstSel   = T_SHARERS;
                stb.purge    = !stat.fromLoc;
              end
              nextState = S_MEMRD;
            end
          end
          default: ;
        endcase
      end
      S_MEMRD: begin
        nextState = S_IDLE;
        if (stat.fromLoc) begin
          stb.resp  = 1'b1;
          stb.dirOp = (stat.kind == K_RWITM) ? D_CLEAR : D_NONE;
        end else begin
          stb.send     = 1'b1;
          stb.sendKind = K_DATA;
          stb.dstSel   = T_SRC;
          stb.dirOp    = (stat.kind == K_RWITM) ? D_TAKE : D_SHARE;
        end
      end
      S_WAITWB: begin
        inReady = (inKind == K_WB) && inAddrMatch;
        if (inValid && inReady) begin
          stb.memWe    = 1'b1;
          stb.wbFromIn = 1'b1;
          stb.dirOp    = D_CLEAN;
          nextState    = S_DECIDE;
        end
      end
      S_WAITRSP: begin
        inReady = (inKind == K_DATA) || (inKind == K_INV) || (inKind == K_RECALL);
        if (inValid && inReady) begin
          if (inKind == K_DATA) begin
            stb.resp       = 1'b1;
            stb.respFromIn = 1'b1;
            nextState      = S_IDLE;
          end else begin
            stb.purge       = 1'b1;
            stb.purgeFromIn = 1'b1;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/node_dir_dp.sv
module node_dir_dp
  import node_dir_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int NODES   = 4,
  parameter int NODE_ID = 0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       stb,
  input  logic [2:0]                    locKind,
  input  logic [ADDR_W-1:0]             locAddr,
  input  logic [DATA_W-1:0]             locWdata,
  input  logic [2:0]                    inKind,
  input  logic [$clog2(NODES)-1:0]      inSrc,
  input  logic [ADDR_W-1:0]             inAddr,
  input  logic [DATA_W-1:0]             inData,
  input  logic [DATA_W-1:0]             memRdata,
  output status_t                       stat,
  output logic                          inAddrMatch,
  output logic                          outValid,
  output logic [2:0]                    outKind,
  output logic [NODES-1:0]              outDstMask,
  output logic [ADDR_W-1:0]             outAddr,
  output logic [DATA_W-1:0]             outData,
  output logic                          memRe,
  output logic                          memWe,
  output logic [ADDR_W-$clog2(NODES)-1:0] memAddr,
  output logic [DATA_W-1:0]             memWdata,
  output logic                          locRespValid,
  output logic [DATA_W-1:0]             locRespData,
  output logic                          purgeValid,
  output logic [ADDR_W-1:0]             purgeAddr
);

  localparam int NODE_BITS = $clog2(NODES);
  localparam int LINE_BITS = ADDR_W - NODE_BITS;
  localparam int DEPTH     = 1 << LINE_BITS;
  localparam logic [NODE_BITS-1:0] SELF = NODE_BITS'(NODE_ID);

  msgKind_e              pendKind;
  logic                  pendFromLoc;
  logic [NODE_BITS-1:0]  pendSrc;
  logic [ADDR_W-1:0]     pendAddr;
  logic [DATA_W-1:0]     pendData;

  logic [NODES-1:0]      shareQ [DEPTH];
  logic                  dirtyQ [DEPTH];
  logic [NODE_BITS-1:0]  ownerQ [DEPTH];

  logic [NODE_BITS-1:0]  pendHome;
  logic [LINE_BITS-1:0]  pendLine;
  logic [NODES-1:0]      srcMask, invMask, curShare;
  logic                  curDirty;
  logic [NODE_BITS-1:0]  curOwner;

  assign pendHome = pendAddr[ADDR_W-1 -: NODE_BITS];
  assign pendLine = pendAddr[LINE_BITS-1:0];
  assign curShare = shareQ[pendLine];
  assign curDirty = dirtyQ[pendLine];
  assign curOwner = ownerQ[pendLine];
  assign srcMask  = pendFromLoc ? '0 : (NODES'(1) << pendSrc);
  assign invMask  = curShare & ~srcMask;

  assign stat.kind       = pendKind;
  assign stat.fromLoc    = pendFromLoc;
  assign stat.remoteHome = (pendHome != SELF);
  assign stat.dirty      = curDirty;
  assign stat.ownerIsSrc = !pendFromLoc && (curOwner == pendSrc);
  assign stat.invAny     = |invMask;

  assign inAddrMatch = (inAddr == pendAddr);
  assign memRe    = stb.memRe;
  assign memWe    = stb.memWe;
  assign memAddr  = pendLine;
  assign memWdata = stb.wbFromIn ? inData : pendData;

  // pending transaction capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendKind    <= K_RD;
      pendFromLoc <= 1'b0;
      pendSrc     <= '0;
      pendAddr    <= '0;
      pendData    <= '0;
    end else if (stb.capIn) begin
      pendKind    <= msgKind_e'(inKind);
      pendFromLoc <= 1'b0;
      pendSrc     <= inSrc;
      pendAddr    <= inAddr;
      pendData    <= inData;
    end else if (stb.capLoc) begin
      pendKind    <= msgKind_e'(locKind);
      pendFromLoc <= 1'b1;
      pendSrc     <= SELF;
      pendAddr    <= locAddr;
      pendData    <= locWdata;
    end
  end

  // directory of home lines
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        shareQ[i] <= '0;
        dirtyQ[i] <= 1'b0;
        ownerQ[i] <= '0;
      end
    end else begin
      case (stb.dirOp)
        D_SHARE: shareQ[pendLine] <= curShare | srcMask;
        D_TAKE: begin
          shareQ[pendLine] <= srcMask;
          dirtyQ[pendLine] <= 1'b1;
          ownerQ[pendLine] <= pendSrc;
        end
        D_CLEAR: begin
          shareQ[pendLine] <= '0;
          dirtyQ[pendLine] <= 1'b0;
        end
        D_CLEAN: dirtyQ[pendLine] <= 1'b0;
        D_EVICT: begin
          shareQ[pendLine] <= curShare & ~srcMask;
          dirtyQ[pendLine] <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      outKind      <= '0;
      outDstMask   <= '0;
      outAddr      <= '0;
      outData      <= '0;
      locRespValid <= 1'b0;
      locRespData  <= '0;
      purgeValid   <= 1'b0;
      purgeAddr    <= '0;
    end else begin
      outValid     <= stb.send;
      locRespValid <= stb.resp;
      purgeValid   <= stb.purge;
      if (stb.send) begin
        outKind <= stb.sendKind;
        outAddr <= pendAddr;
        outData <= (stb.sendKind == K_DATA) ? memRdata : pendData;
        case (stb.dstSel)
          T_HOME:  outDstMask <= NODES'(1) << pendHome;
          T_SRC:   outDstMask <= NODES'(1) << pendSrc;
          T_OWNER: outDstMask <= NODES'(1) << curOwner;
          default: outDstMask <= invMask;
        endcase
      end
      if (stb.resp)  locRespData <= stb.respFromIn ? inData : memRdata;
      if (stb.purge) purgeAddr   <= stb.purgeFromIn ? inAddr : pendAddr;
    end
  end

endmodule

// File: rtl/node_dir_ctrl.sv
module node_dir_ctrl
  import node_dir_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int NODES   = 4,
  parameter int NODE_ID = 0
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            locValid,
  input  logic [2:0]                      locKind,
  input  logic [ADDR_W-1:0]               locAddr,
  input  logic [DATA_W-1:0]               locWdata,
  output logic                            locReady,
  output logic                            locRespValid,
  output logic [DATA_W-1:0]               locRespData,
  input  logic                            inValid,
  input  logic [2:0]                      inKind,
  input  logic [$clog2(NODES)-1:0]        inSrc,
  input  logic [ADDR_W-1:0]               inAddr,
  input  logic [DATA_W-1:0]               inData,
  output logic                            inReady,
  output logic                            outValid,
  output logic [2:0]                      outKind,
  output logic [NODES-1:0]                outDstMask,
  output logic [ADDR_W-1:0]               outAddr,
  output logic [DATA_W-1:0]               outData,
  output logic                            memRe,
  output logic                            memWe,
  output logic [ADDR_W-$clog2(NODES)-1:0] memAddr,
  output logic [DATA_W-1:0]               memWdata,
  input  logic [DATA_W-1:0]               memRdata,
  output logic                            purgeValid,
  output logic [ADDR_W-1:0]               purgeAddr
);

  strobe_t stb;
  status_t stat;
  logic    inAddrMatch;

  node_dir_ctl uCtl (
    .clk, .rstN, .locValid, .inValid, .inKind, .inAddrMatch,
    .stat, .stb, .locReady, .inReady
  );

  node_dir_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NODES(NODES), .NODE_ID(NODE_ID)
  ) uDp (
    .clk, .rstN, .stb, .locKind, .locAddr, .locWdata,
    .inKind, .inSrc, .inAddr, .inData, .memRdata,
    .stat, .inAddrMatch, .outValid, .outKind, .outDstMask, .outAddr, .outData,
    .memRe, .memWe, .memAddr, .memWdata,
    .locRespValid, .locRespData, .purgeValid, .purgeAddr
  );

endmodule

// File: rtl/node_dir_chk.sv
module node_dir_chk #(
  parameter int NODES   = 4,
  parameter int NODE_ID = 0
) (
  input logic             clk,
  input logic             rstN,
  input logic             locReady,
  input logic             locRespValid,
  input logic             outValid,
  input logic [2:0]       outKind,
  input logic [NODES-1:0] outDstMask
);

  logic waitQ;

  always_ff @(posedge clk) begin
    if (!rstN)                                   waitQ <= 1'b0;
    else if (locRespValid)                       waitQ <= 1'b0;
    else if (outValid && (outKind == 3'd0 || outKind == 3'd1)) waitQ <= 1'b1;
  end

  // R4: no local acceptance while a remote request is open
  a_r4_hold_local: assert property (@(posedge clk) disable iff (!rstN)
    (waitQ && !locRespValid) |-> !locReady);

  // R2: remote requests target exactly one other node
  a_r2_one_home: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (outKind == 3'd0 || outKind == 3'd1)) |-> ($onehot(outDstMask) && !outDstMask[NODE_ID]));

  // R8: recalls target one remote owner
  a_r8_recall_target: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == 3'd4) |-> ($onehot(outDstMask) && !outDstMask[NODE_ID]));

  // R5: data replies go to one remote requester
  a_r5_data_target: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == 3'd5) |-> ($onehot(outDstMask) && !outDstMask[NODE_ID]));

  // R6: local responses are single-cycle pulses
  a_r6_resp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    locRespValid |=> !locRespValid);

endmodule

bind node_dir_ctrl node_dir_chk #(.NODES(NODES), .NODE_ID(NODE_ID)) uChk (
  .clk(clk), .rstN(rstN), .locReady(locReady), .locRespValid(locRespValid),
  .outValid(outValid), .outKind(outKind), .outDstMask(outDstMask)
);

// File: tb/tb_node_dir_ctrl.sv
module tb_node_dir_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        locValid = 1'b0;
  logic [2:0]  locKind = '0;
  logic [7:0]  locAddr = '0;
  logic [15:0] locWdata = '0;
  logic        locReady, locRespValid;
  logic [15:0] locRespData;
  logic        inValid = 1'b0;
  logic [2:0]  inKind = '0;
  logic [1:0]  inSrc = '0;
  logic [7:0]  inAddr = '0;
  logic [15:0] inData = '0;
  logic        inReady, outValid;
  logic [2:0]  outKind;
  logic [3:0]  outDstMask;
  logic [7:0]  outAddr;
  logic [15:0] outData;
  logic        memRe, memWe;
  logic [5:0]  memAddr;
  logic [15:0] memWdata;
  logic [15:0] memRdata = '0;
  logic        purgeValid;
  logic [7:0]  purgeAddr;

  node_dir_ctrl dut (.*);

  always #5 clk = ~clk;

  // memory model
  logic [15:0] mem [64];
  initial for (int i = 0; i < 64; i++) mem[i] = 16'hA000 + 16'(i);
  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    if (memRe) memRdata <= mem[memAddr];
  end

  // monitors
  int cyc = 0, outN = 0, respN = 0, purgeN = 0, respCyc = 0, dataCyc = 0;
  logic [2:0]  logKind [64];
  logic [3:0]  logMask [64];
  logic [7:0]  logAddr [64];
  logic [15:0] logData [64];
  logic [15:0] lastResp = '0;
  logic [7:0]  lastPurge = '0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (outValid && outN < 64) begin
      logKind[outN] = outKind; logMask[outN] = outDstMask;
      logAddr[outN] = outAddr; logData[outN] = outData;
      if (outKind == 3'd5) dataCyc = cyc;
      outN++;
    end
    if (locRespValid) begin respN++; lastResp = locRespData; respCyc = cyc; end
    if (purgeValid)   begin purgeN++; lastPurge = purgeAddr; end
  end

  int checks = 0, errors = 0;
  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doLoc(input logic [2:0] k, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    locValid = 1'b1; locKind = k; locAddr = a; locWdata = d;
    #1;
    while (!locReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    locValid = 1'b0;
  endtask

  task automatic sendIn(input logic [2:0] k, input logic [1:0] s, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    inValid = 1'b1; inKind = k; inSrc = s; inAddr = a; inData = d;
    #1;
    while (!inReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  // {kind, addr, data} for remote-homed local requests
  localparam logic [26:0] VECS [6] = '{
    {3'd0, 8'h45, 16'h1111}, {3'd0, 8'h8A, 16'h2222}, {3'd1, 8'hC3, 16'h3333},
    {3'd1, 8'h7F, 16'h4444}, {3'd0, 8'hFF, 16'h5555}, {3'd1, 8'h80, 16'h6666}
  };

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n0, r0, p0;
    waitN(3);
    chk("R1", "outValid in reset", outValid, 0);
    chk("R1", "locRespValid in reset", locRespValid, 0);
    chk("R1", "purgeValid in reset", purgeValid, 0);
    chk("R1", "memWe in reset", memWe, 0);
    rstN = 1'b1;
    waitN(1);
    chk("R1", "locReady after reset", locReady, 1);
    chk("R1", "inReady after reset", inReady, 1);

    // table walk: remote-homed requests and their responses
    for (int i = 0; i < 6; i++) begin
      logic [2:0] k; logic [7:0] a; logic [15:0] d;
      {k, a, d} = VECS[i];
      n0 = outN; r0 = respN;
      doLoc(k, a, 16'h0);
      waitN(3);
      chk("R2", "request count", outN - n0, 1);
      chk("R2", "request kind", logKind[n0], k);
      chk("R2", "home mask", logMask[n0], 4'b1 << a[7:6]);
      chk("R2", "request addr", logAddr[n0], a);
      if (i == 0) begin
        chk("R4", "locReady while open", locReady, 0);
        p0 = purgeN;
        sendIn(3'd3, 2'd2, 8'h85, 16'h0);
        waitN(2);
        chk("R10", "purge while open", purgeN - p0, 1);
        chk("R10", "purge addr", lastPurge, 8'h85);
        chk("R4", "still no response", respN - r0, 0);
      end
      sendIn(3'd5, a[7:6], a, d);
      waitN(3);
      chk("R3", "response count", respN - r0, 1);
      chk("R3", "response data", lastResp, d);
    end

    // R6: local read of clean home line
    n0 = outN; r0 = respN;
    doLoc(3'd0, 8'h05, 16'h0);
    waitN(5);
    chk("R6", "no link message", outN - n0, 0);
    chk("R6", "local data", lastResp, 16'hA005);

    // R5: two remote readers
    n0 = outN;
    sendIn(3'd0, 2'd2, 8'h05, 16'h0);
    waitN(5);
    chk("R5", "data kind", logKind[n0], 3'd5);
    chk("R5", "data dst", logMask[n0], 4'b0100);
    chk("R5", "data value", logData[n0], 16'hA005);
    sendIn(3'd0, 2'd3, 8'h05, 16'h0);
    waitN(5);
    chk("R5", "second dst", logMask[n0+1], 4'b1000);

    // R7: remote ownership take invalidates other sharer
    n0 = outN; p0 = purgeN;
    sendIn(3'd1, 2'd2, 8'h05, 16'h0);
    waitN(6);
    chk("R7", "message count", outN - n0, 2);
    chk("R7", "inv kind", logKind[n0], 3'd3);
    chk("R7", "inv mask", logMask[n0], 4'b1000);
    chk("R7", "data dst", logMask[n0+1], 4'b0100);
    chk("R7", "local purge", purgeN - p0, 1);
    chk("R7", "purge addr", lastPurge, 8'h05);

    // R8: local read of remotely dirty line forces recall
    n0 = outN; r0 = respN;
    doLoc(3'd0, 8'h05, 16'h0);
    waitN(5);
    chk("R8", "recall kind", logKind[n0], 3'd4);
    chk("R8", "recall dst", logMask[n0], 4'b0100);
    chk("R8", "no data before writeback", respN - r0, 0);
    sendIn(3'd2, 2'd2, 8'h05, 16'hBEEF);
    waitN(5);
    chk("R8", "response after writeback", respN - r0, 1);
    chk("R8", "written data returned", lastResp, 16'hBEEF);
    chk("R8", "memory updated", mem[5], 16'hBEEF);

    // R9: local ownership take clears the entry
    n0 = outN;
    doLoc(3'd1, 8'h05, 16'h0);
    waitN(6);
    chk("R9", "inv count", outN - n0, 1);
    chk("R9", "inv mask", logMask[n0], 4'b0100);
    chk("R9", "local data", lastResp, 16'hBEEF);
    n0 = outN;
    sendIn(3'd1, 2'd3, 8'h05, 16'h0);
    waitN(6);
    chk("R9", "no inv after clear", outN - n0, 1);
    chk("R9", "only data sent", logKind[n0], 3'd5);

    // R11: voluntary remote writeback
    n0 = outN;
    sendIn(3'd2, 2'd3, 8'h05, 16'h1234);
    waitN(4);
    chk("R11", "memory written", mem[5], 16'h1234);
    doLoc(3'd1, 8'h05, 16'h0);
    waitN(6);
    chk("R11", "no recall or inv", outN - n0, 0);
    chk("R11", "fresh data", lastResp, 16'h1234);

    // R12: local writeback to remote home
    n0 = outN; r0 = respN;
    doLoc(3'd2, 8'hC7, 16'h5555);
    waitN(4);
    chk("R12", "forward kind", logKind[n0], 3'd2);
    chk("R12", "forward dst", logMask[n0], 4'b1000);
    chk("R12", "forward data", logData[n0], 16'h5555);
    chk("R12", "no local response", respN - r0, 0);

    // R13: link message beats local request
    n0 = outN;
    fork
      doLoc(3'd0, 8'h06, 16'h0);
      sendIn(3'd0, 2'd1, 8'h07, 16'h0);
    join
    waitN(8);
    chk("R13", "remote data dst", logMask[n0], 4'b0010);
    chk("R13", "remote data", logData[n0], 16'hA007);
    chk("R13", "local data", lastResp, 16'hA006);
    chk("R13", "remote served first", (dataCyc < respCyc) ? 1 : 0, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule